// File: doc/BRIEF.md
# DMA Page Register Address Extension

This block widens the 16-bit address produced by a DMA controller into a full physical bus address. It holds a small file of page registers that the processor loads through I/O write cycles at fixed port numbers. While the controller owns the bus, the active-low channel acknowledge lines pick one page register, and that page is joined to the controller's 16-bit offset to form the outgoing address. The page and the offset are joined without any carry, so a transfer that runs past offset FFFFh wraps back to the start of the same 64 KB window.

A build parameter picks between two flavours. In the narrow flavour the pages are 4 bits wide and the bus address is 20 bits. In the wide flavour the pages are 8 bits wide, the bus address is 24 bits, and a second bank of page registers serves a word-wide controller. That word controller's offset is shifted left by one bit and the lowest page bit is dropped, so it reaches aligned words across a 128 KB window.

The page selection comes straight from two acknowledge lines and not from a channel number. As a result, channels 0 and 1, memory-to-memory transfers and a grant with no acknowledge all share a single page register.

Top module: `dma_page_ext`

## Requirements
- R1: After reset every page register reads as zero, so a granted byte transfer addresses page 0.
- R2: An I/O write to byte port 80h+k (k = 0..3) loads byte page register k from the write data. The new page appears on the bus address from the clock after the write.
- R3: The byte bank index is {dack_n[2], dack_n[3]}. With only acknowledge 2 low, register 1 (port 81h) is used. With only acknowledge 3 low, register 2 (port 82h) is used.
- R4: With acknowledge 0 or 1 low, or with no acknowledge low, both select bits are high and register 3 (port 83h) is used.
- R5: With acknowledges 2 and 3 both low, register 0 (port 80h) is used.
- R6: A byte-transfer address is {page, offset}, with the offset in bits 15:0. There is no carry from the offset into the page, so offset FFFFh stays inside the page's 64 KB window.
- R7: In the wide flavour (AT_MODE=1) pages are 8 bits and the address is 24 bits. In the narrow flavour (AT_MODE=0) pages keep only write data bits 3:0 and the address is 20 bits.
- R8: In the wide flavour only, word ports 88h..8Bh load word page registers 0..3. The word bank index is {word_dack_n[2], word_dack_n[3]}, where word_dack_n[0..3] are channels 4..7. A word address is {page[7:1], offset, 0}: page bit 0 is ignored and address bit 0 is always zero.
- R9: With no grant active, bus_addr_oe is low and bus_addr is zero.
- R10: A write to one register, or to an unmapped port (84h..87h, 8Ch..8Fh and any other port), leaves the address of a transfer that uses a different register unchanged.
- R11: When byte and word grants are both active, the byte path drives the address.
- R12: In the narrow flavour the word grant, the word acknowledges and the word ports have no effect: a word grant alone leaves bus_addr_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| byte_grant | input | 1 | Byte controller owns the bus |
| byte_dack_n | input | 4 | Byte controller acknowledges, active low, channels 0..3 |
| word_grant | input | 1 | Word controller owns the bus (wide flavour) |
| word_dack_n | input | 4 | Word controller acknowledges, active low, channels 4..7 |
| dma_addr | input | 16 | Offset from the active controller |
| bus_addr | output | 16+page width | Physical bus address |
| bus_addr_oe | output | 1 | Address output enable |

## Verification
The bench targets the shared-page decode. A design that decoded a channel number would give channels 0 and 1, or the both-low case, their own pages, and the bench would see the wrong page. It drives offset FFFFh and checks that an adder-based design, which would carry into the page, is caught. On the word path it sets page bit 0 and checks that it is dropped and that the offset is shifted. A design that kept bit 0, or failed to shift the offset, would misplace every word. It also mixes writes into the middle of transfers, hits unmapped ports and raises both grants at once, so that a wrong write decode or a wrong path priority shows up as a changed address.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
    localparam int OFF_W    = 16;
    localparam int PORT_W   = 8;
    localparam int DATA_W   = 8;
    localparam int NREG     = 4;
    localparam int SEL_W    = $clog2(NREG);
    localparam int DACK_W   = 4;
    localparam logic [PORT_W-1:0] BYTE_BASE = 8'h80;
    localparam logic [PORT_W-1:0] WORD_BASE = 8'h88;

    // Select bit B comes from acknowledge 2, select bit A from acknowledge 3.
    function automatic logic [SEL_W-1:0] dack_to_sel(input logic [DACK_W-1:0] dn);
        return {dn[2], dn[3]};
    endfunction
endpackage

// File: rtl/page_port_decode.sv
module page_port_decode
    import dma_page_pkg::*;
#(
    parameter logic [PORT_W-1:0] BASE = 8'h80,
    parameter int DEPTH = NREG
) (
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_addr,
    output logic [DEPTH-1:0]  wr_en
);
    genvar k;
    generate
        for (k = 0; k < DEPTH; k++) begin : g_port
            localparam logic [PORT_W-1:0] PORT = BASE + PORT_W'(k);
            assign wr_en[k] = io_wr && (io_addr == PORT);
        end
    endgenerate
endmodule

// File: rtl/page_reg_bank.sv
module page_reg_bank
    import dma_page_pkg::*;
#(
    parameter int DEPTH = NREG,
    parameter int W     = 8,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] wr_en,
    input  logic [W-1:0]     wdata,
    input  logic [SW-1:0]    sel,
    output logic [W-1:0]     rd_page
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] page;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en[i]) bank_d.page[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rd_page = bank_q.page[sel];
endmodule

// File: rtl/page_addr_form.sv
module page_addr_form
    import dma_page_pkg::*;
#(
    parameter bit AT_MODE = 1'b1,
    localparam int PG_W   = AT_MODE ? 8 : 4,
    localparam int ADDR_W = OFF_W + PG_W
) (
    input  logic              byte_grant,
    input  logic              word_grant,
    input  logic [PG_W-1:0]   byte_page,
    input  logic [7:0]        word_page,
    input  logic [OFF_W-1:0]  dma_addr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_oe
);
    logic [ADDR_W-1:0] byte_addr;
    logic [ADDR_W-1:0] word_addr;
    logic              word_live;

    assign byte_addr = {byte_page, dma_addr};

    generate
        if (AT_MODE) begin : g_word
            logic unused_page_lsb;
            assign unused_page_lsb = word_page[0];
            assign word_addr = {word_page[7:1], dma_addr, 1'b0};
            assign word_live = word_grant;
        end else begin : g_noword
            logic unused_word;
            assign unused_word = ^{word_page, word_grant};
            assign word_addr = '0;
            assign word_live = 1'b0;
        end
    endgenerate

    always_comb begin
        bus_addr    = '0;
        bus_addr_oe = 1'b0;
        if (byte_grant) begin
            bus_addr    = byte_addr;
            bus_addr_oe = 1'b1;
        end else if (word_live) begin
            bus_addr    = word_addr;
            bus_addr_oe = 1'b1;
        end
    end
endmodule

// File: rtl/dma_page_ext.sv
module dma_page_ext
    import dma_page_pkg::*;
#(
    parameter bit AT_MODE = 1'b1,
    localparam int PG_W   = AT_MODE ? 8 : 4,
    localparam int ADDR_W = OFF_W + PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              byte_grant,
    input  logic [3:0]        byte_dack_n,
    input  logic              word_grant,
    input  logic [3:0]        word_dack_n,
    input  logic [15:0]       dma_addr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_addr_oe
);
    logic [NREG-1:0] byte_wr_en;
    logic [PG_W-1:0] byte_page;
    logic [7:0]      word_page;

    page_port_decode #(.BASE(BYTE_BASE), .DEPTH(NREG)) u_byte_dec (
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .wr_en   (byte_wr_en)
    );

    page_reg_bank #(.DEPTH(NREG), .W(PG_W)) u_byte_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (byte_wr_en),
        .wdata   (io_wdata[PG_W-1:0]),
        .sel     (dack_to_sel(byte_dack_n)),
        .rd_page (byte_page)
    );

    generate
        if (AT_MODE) begin : g_word_bank
            logic [NREG-1:0] word_wr_en;

            page_port_decode #(.BASE(WORD_BASE), .DEPTH(NREG)) u_word_dec (
                .io_wr   (io_wr),
                .io_addr (io_addr),
                .wr_en   (word_wr_en)
            );

            page_reg_bank #(.DEPTH(NREG), .W(8)) u_word_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (word_wr_en),
                .wdata   (io_wdata),
                .sel     (dack_to_sel(word_dack_n)),
                .rd_page (word_page)
            );
        end else begin : g_no_word_bank
            logic unused_word_in;
            assign unused_word_in = ^{word_dack_n, io_wdata};
            assign word_page = '0;
        end
    endgenerate

    page_addr_form #(.AT_MODE(AT_MODE)) u_form (
        .byte_grant  (byte_grant),
        .word_grant  (word_grant),
        .byte_page   (byte_page),
        .word_page   (word_page),
        .dma_addr    (dma_addr),
        .bus_addr    (bus_addr),
        .bus_addr_oe (bus_addr_oe)
    );
endmodule

// File: rtl/dma_page_ext_chk.sv
module dma_page_ext_chk #(
    parameter bit AT_MODE = 1'b1,
    localparam int PG_W   = AT_MODE ? 8 : 4,
    localparam int ADDR_W = 16 + PG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [7:0]        io_addr,
    input logic              byte_grant,
    input logic [3:0]        byte_dack_n,
    input logic              word_grant,
    input logic [15:0]       dma_addr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_addr_oe
);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_grant && !(AT_MODE && word_grant)) |-> (!bus_addr_oe && bus_addr == '0));

    p_grant_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_grant || (AT_MODE && word_grant)) |-> bus_addr_oe);

    // R6 and R11: the byte path owns the offset bits whenever byte_grant is up.
    p_offset_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_grant |-> (bus_addr[15:0] == dma_addr));

    p_shared_page_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_grant && byte_dack_n == 4'hF && (!io_wr || io_addr != 8'h83))
        |=> (!(byte_grant && byte_dack_n == 4'hF) || $stable(bus_addr[ADDR_W-1:16])));

    generate
        if (AT_MODE) begin : g_word_chk
            p_word_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!byte_grant && word_grant) |-> (bus_addr[0] == 1'b0 && bus_addr[16:1] == dma_addr));
        end else begin : g_pc_chk
            p_no_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
                (!byte_grant && word_grant) |-> !bus_addr_oe);
        end
    endgenerate
endmodule

bind dma_page_ext dma_page_ext_chk #(.AT_MODE(AT_MODE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_wr       (io_wr),
    .io_addr     (io_addr),
    .byte_grant  (byte_grant),
    .byte_dack_n (byte_dack_n),
    .word_grant  (word_grant),
    .dma_addr    (dma_addr),
    .bus_addr    (bus_addr),
    .bus_addr_oe (bus_addr_oe)
);

// File: tb/dma_page_ext_test.sv
module dma_page_ext_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        byte_grant = 1'b0;
    logic [3:0]  byte_dack_n = 4'hF;
    logic        word_grant = 1'b0;
    logic [3:0]  word_dack_n = 4'hF;
    logic [15:0] dma_addr = '0;
    logic [23:0] at_addr;
    logic        at_oe;
    logic [19:0] pc_addr;
    logic        pc_oe;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] at_b [4];
    logic [7:0] at_w [4];
    logic [3:0] pc_b [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_page_ext #(.AT_MODE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .byte_grant(byte_grant), .byte_dack_n(byte_dack_n), .word_grant(word_grant),
        .word_dack_n(word_dack_n), .dma_addr(dma_addr), .bus_addr(at_addr), .bus_addr_oe(at_oe)
    );

    dma_page_ext #(.AT_MODE(1'b0)) uut_pc (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .byte_grant(byte_grant), .byte_dack_n(byte_dack_n), .word_grant(word_grant),
        .word_dack_n(word_dack_n), .dma_addr(dma_addr), .bus_addr(pc_addr), .bus_addr_oe(pc_oe)
    );

    function automatic int idx(input logic [3:0] dn);
        return int'({dn[2], dn[3]});
    endfunction

    function automatic logic [24:0] exp_at();
        if (byte_grant)      return {1'b1, at_b[idx(byte_dack_n)], dma_addr};
        else if (word_grant) return {1'b1, at_w[idx(word_dack_n)][7:1], dma_addr, 1'b0};
        else                 return '0;
    endfunction

    function automatic logic [20:0] exp_pc();
        if (byte_grant) return {1'b1, pc_b[idx(byte_dack_n)], dma_addr};
        else            return '0;
    endfunction

    task automatic step(input bit wr, input logic [7:0] wa, input logic [7:0] wd,
                        input bit bg, input bit wg, input logic [3:0] bdn,
                        input logic [3:0] wdn, input logic [15:0] off, input string tag);
        logic [24:0] ea;
        logic [20:0] ep;
        @(negedge clk);
        io_wr = wr; io_addr = wa; io_wdata = wd;
        byte_grant = bg; word_grant = wg; byte_dack_n = bdn; word_dack_n = wdn; dma_addr = off;
        #1;
        ea = exp_at();
        ep = exp_pc();
        vectors++;
        if ({at_oe, at_addr} !== ea) begin
            fails++;
            $display("FAIL %s wide: got oe=%0b addr=%06h expected oe=%0b addr=%06h",
                     tag, at_oe, at_addr, ea[24], ea[23:0]);
        end
        vectors++;
        if ({pc_oe, pc_addr} !== ep) begin
            fails++;
            $display("FAIL %s narrow: got oe=%0b addr=%05h expected oe=%0b addr=%05h",
                     tag, pc_oe, pc_addr, ep[20], ep[19:0]);
        end
        @(posedge clk);
        if (wr) begin
            if (wa >= 8'h80 && wa <= 8'h83) begin
                at_b[wa - 8'h80] = wd;
                pc_b[wa - 8'h80] = wd[3:0];
            end
            if (wa >= 8'h88 && wa <= 8'h8B) at_w[wa - 8'h88] = wd;
        end
    endtask

    task automatic idle_rd(input bit bg, input bit wg, input logic [3:0] bdn,
                           input logic [3:0] wdn, input logic [15:0] off, input string tag);
        step(1'b0, 8'h00, 8'h00, bg, wg, bdn, wdn, off, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            at_b[i] = '0; at_w[i] = '0; pc_b[i] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset pages are zero on every select
        idle_rd(1'b1, 1'b0, 4'hF, 4'hF, 16'h1234, "R1 reset");
        idle_rd(1'b1, 1'b0, 4'b1011, 4'hF, 16'h00FF, "R1 reset");
        idle_rd(1'b0, 1'b1, 4'hF, 4'hF, 16'h4321, "R1 reset word");
        // R9: no grant
        idle_rd(1'b0, 1'b0, 4'b1110, 4'hF, 16'hBEEF, "R9 idle");
        // R2, R4, R7: load port 83h, used with no acknowledge and acknowledge 0/1
        step(1'b1, 8'h83, 8'hA5, 1'b1, 1'b0, 4'hF, 4'hF, 16'h0010, "R2 before load");
        idle_rd(1'b1, 1'b0, 4'hF, 4'hF, 16'h0010, "R2 R7 after load");
        idle_rd(1'b1, 1'b0, 4'b1110, 4'hF, 16'h0020, "R4 dack0");
        idle_rd(1'b1, 1'b0, 4'b1101, 4'hF, 16'h0030, "R4 dack1");
        // R3: acknowledges 2 and 3
        step(1'b1, 8'h81, 8'h3C, 1'b0, 1'b0, 4'hF, 4'hF, 16'h0, "R3 load81");
        step(1'b1, 8'h82, 8'h77, 1'b0, 1'b0, 4'hF, 4'hF, 16'h0, "R3 load82");
        idle_rd(1'b1, 1'b0, 4'b1011, 4'hF, 16'h5555, "R3 dack2");
        idle_rd(1'b1, 1'b0, 4'b0111, 4'hF, 16'hAAAA, "R3 dack3");
        // R5: both low select register 0
        step(1'b1, 8'h80, 8'h9E, 1'b0, 1'b0, 4'hF, 4'hF, 16'h0, "R5 load80");
        idle_rd(1'b1, 1'b0, 4'b0011, 4'hF, 16'h0101, "R5 both low");
        // R6: no carry past FFFFh
        idle_rd(1'b1, 1'b0, 4'hF, 4'hF, 16'hFFFF, "R6 top offset");
        idle_rd(1'b1, 1'b0, 4'hF, 4'hF, 16'h0000, "R6 wrap");
        // R8: word bank, odd page with bit 0 ignored
        step(1'b1, 8'h89, 8'h5B, 1'b0, 1'b0, 4'hF, 4'hF, 16'h0, "R8 load89");
        step(1'b1, 8'h8A, 8'hFF, 1'b0, 1'b0, 4'hF, 4'hF, 16'h0, "R8 load8A");
        idle_rd(1'b0, 1'b1, 4'hF, 4'b1011, 16'h8001, "R8 ch6");
        idle_rd(1'b0, 1'b1, 4'hF, 4'b0111, 16'hFFFF, "R8 ch7");
        idle_rd(1'b0, 1'b1, 4'hF, 4'hF, 16'h7FFF, "R8 none");
        // R12: narrow flavour ignores word grant (checked on uut_pc above), word port write
        step(1'b1, 8'h8B, 8'h42, 1'b0, 1'b1, 4'hF, 4'hF, 16'h1111, "R12 word write");
        idle_rd(1'b0, 1'b1, 4'hF, 4'hF, 16'h2222, "R12 word grant");
        // R10: writes elsewhere during a transfer on register 3
        step(1'b1, 8'h81, 8'h12, 1'b1, 1'b0, 4'hF, 4'hF, 16'h3000, "R10 other write");
        step(1'b1, 8'h8E, 8'hC3, 1'b1, 1'b0, 4'hF, 4'hF, 16'h3001, "R10 unmapped");
        step(1'b1, 8'h85, 8'hC3, 1'b1, 1'b0, 4'hF, 4'hF, 16'h3002, "R10 unmapped");
        idle_rd(1'b1, 1'b0, 4'hF, 4'hF, 16'h3003, "R10 page held");
        // R11: both grants
        idle_rd(1'b1, 1'b1, 4'b1011, 4'b1011, 16'h6006, "R11 both grants");

        // R2 R3 R4 R5 R6 R7 R8 R10: random mix
        for (int n = 0; n < 2000; n++) begin
            logic [3:0] bdn, wdn;
            bdn = ($urandom % 2) ? ~(4'b1 << ($urandom % 4)) : 4'($urandom);
            wdn = ($urandom % 2) ? ~(4'b1 << ($urandom % 4)) : 4'($urandom);
            step(($urandom % 3) == 0, 8'h80 + 8'($urandom % 16), 8'($urandom),
                 ($urandom % 4) != 0, ($urandom % 2) == 0, bdn, wdn, 16'($urandom),
                 "R2/R7 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule